// File: doc/BRIEF.md
# Sampling Converter Serial Sequencer

This block is the digital controller and serial port of a low-power sampling converter. It cycles through three phases. The first is a conversion of fixed length. The second is a low-power wait that holds the result. The third is a serial transfer that shifts the result out and takes in two configuration bits. A programmable cycle counter stands in for the modulator and its filter. When that count runs out, the block latches the word on a parallel sample port into a holding register.

A host reads the result by pulling chip select low and clocking 16 bits out of the serial data output. While it does so, it writes a rate bit and a power-mode bit on the serial data input. The transfer ends on the sixteenth falling serial clock edge. Raising chip select earlier aborts it. Either event starts the next conversion.

The serial data output is presented as a data bit plus an output enable, and the enable is low whenever chip select is high. The pad ring builds the tri-state driver from that pair. Two power-enable outputs switch the converter and the voltage reference. In nap mode only the converter is turned off during the wait. In sleep mode the reference is turned off as well.

Top module: `conv_spi_seq`

## Requirements
- R1: During and straight after reset (synchronous, active-low `rst_n`) the block is converting: `adc_pwr_en_o`=1, `ref_pwr_en_o`=1, `sdo_oe_o`=0. The rate is slow and the mode is nap.
- R2: A conversion lasts exactly SLOW_CYCLES system clocks at the slow rate and FAST_CYCLES at the fast rate. This is the number of cycles for which `adc_pwr_en_o` stays high.
- R3: Once a conversion has started, no chip select or serial clock activity shortens or ends it.
- R4: When the conversion finishes, the block enters the wait phase and captures `sample_i` from that clock cycle. The captured word does not change for the whole wait, even if `sample_i` changes.
- R5: The block leaves the wait phase only when the synchronised chip select is low, and it then enters the transfer phase. While chip select stays high it waits indefinitely.
- R6: `adc_pwr_en_o` is high only during a conversion. It is low throughout the wait and transfer phases.
- R7: During the wait, `ref_pwr_en_o` is 0 if the most recent transfer wrote 1 (sleep) as its second configuration bit. It is 1 if that bit was 0 (nap). Outside the wait it is 1.
- R8: `sdo_oe_o` equals the inverse of `cs_n_i` delayed by two system clocks. The result MSB is on `sdo_o` before the first serial clock edge. Each falling serial clock edge moves the next lower bit onto `sdo_o` by the third system clock edge after it.
- R9: The sixteenth falling serial clock edge ends the transfer even if chip select stays low. `adc_pwr_en_o` rises on the third system clock edge after that serial clock edge.
- R10: Chip select going high during a transfer aborts it. The remaining bits are not shifted, and a new conversion starts on the third system clock edge after the chip select edge. Configuration bits already written are kept.
- R11: Serial input bits are taken on rising serial clock edges. The first bit selects the rate (1 = fast, 0 = slow) and the second selects the mode (1 = sleep, 0 = nap). Both apply from the next conversion, and all later bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sample_i | input | DATA_W | Parallel result from the conversion datapath |
| cs_n_i | input | 1 | Serial chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, idle low, asynchronous |
| sdi_i | input | 1 | Serial configuration input |
| sdo_o | output | 1 | Serial result bit |
| sdo_oe_o | output | 1 | Output enable for the serial result pad |
| adc_pwr_en_o | output | 1 | Converter power enable |
| ref_pwr_en_o | output | 1 | Reference power enable |

## Verification
The serial inputs pass through a two-flop synchroniser, and the serial clock also goes through an edge-detect stage. As a result, the output enable follows chip select after two system clocks. A serial clock or chip select edge shows its effect on the data bit or the power enables at the third system clock edge after it. A conversion holds the converter enable high for exactly its programmed count. The bench changes every input at falling clock edges and keeps a behavioural model that mirrors these latencies and is compared with every output on every falling edge. The directed checks sample at the second and third falling edges after the serial clock or chip select edge that ends a transfer, to pin the handover cycle exactly. They also measure each conversion's enable length against the rate that the preceding transfer wrote.

// File: rtl/conv_spi_pkg.sv
// Shared types for the sampling converter sequencer.
// Assumes: one controller per converter; the state encoding is internal only.
package conv_spi_pkg;
    typedef enum logic [1:0] {
        ST_CONV = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } seq_state_t;

    // Number of configuration bits taken from the serial input per transfer.
    localparam int unsigned CFG_BITS = 2;
endpackage

// File: rtl/seq_sync.sv
// Two-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is independent; inputs change slower than the clock.
module seq_sync #(
    parameter int unsigned   N       = 3,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [1:0] pipe;

        // Two-stage capture of one asynchronous input bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe <= {2{RST_VAL[i]}};
            end else begin
                pipe <= {pipe[0], async_i[i]};
            end
        end

        assign level_o[i] = pipe[1];
    end
endmodule

// File: rtl/seq_conv_timer.sv
// Conversion length counter standing in for the modulator and filter.
// Assumes: run_i stays high for the whole conversion and drops right after done_o.
module seq_conv_timer #(
    parameter int unsigned SLOW_CYCLES = 800000,
    parameter int unsigned FAST_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    output logic done_o
);
    localparam int unsigned MAX_CYCLES = (SLOW_CYCLES > FAST_CYCLES) ? SLOW_CYCLES : FAST_CYCLES;
    localparam int unsigned CW         = $clog2(MAX_CYCLES + 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_CYCLES - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    assign last_val = fast_i ? FAST_LAST : SLOW_LAST;
    assign done_o   = run_i && (cnt_q == last_val);

    // Count cycles spent converting; clear when idle or finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/seq_shifter.sv
// Result holding register that doubles as the serial output shifter.
// Assumes: load_i, start_i and shift_i are never high together.
module seq_shifter #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              start_i,
    input  logic              shift_i,
    output logic              msb_o,
    output logic              done_o
);
    localparam int unsigned   BW       = $clog2(DATA_W + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    logic [DATA_W-1:0] word_q;
    logic [BW-1:0]     bits_q;

    assign msb_o  = word_q[DATA_W-1];
    assign done_o = shift_i && (bits_q == LAST_BIT);

    // Capture a finished result, or move the next bit to the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= data_i;
        end else if (shift_i) begin
            word_q <= {word_q[DATA_W-2:0], 1'b0};
        end
    end

    // Count shifted bits within one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            bits_q <= '0;
        end else if (shift_i) begin
            bits_q <= bits_q + 1'b1;
        end
    end
endmodule

// File: rtl/conv_spi_seq.sv
// Sequencer for a low-power sampling converter: conversion, wait, serial transfer.
// Assumes: serial inputs are asynchronous and the serial clock runs at no more
// than a quarter of clk; the serial clock idles low.
module conv_spi_seq
    import conv_spi_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SLOW_CYCLES = 800000,
    parameter int unsigned FAST_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              adc_pwr_en_o,
    output logic              ref_pwr_en_o
);
    localparam int unsigned RC_W = $clog2(CFG_BITS + 1);

    seq_state_t    state_q;
    logic [2:0]    sync_lvl;
    logic          cs_lvl, sck_lvl, sdi_lvl, sck_d;
    logic          sck_rise, sck_fall;
    logic          tmr_done, xfer_done;
    logic          rate_fast_q, sleep_q;
    logic [RC_W-1:0] rise_cnt_q;
    logic          load_res, start_xfer, shift_bit;

    seq_sync #(.N(3), .RST_VAL(3'b001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sck_i, cs_n_i}),
        .level_o (sync_lvl)
    );

    assign cs_lvl  = sync_lvl[0];
    assign sck_lvl = sync_lvl[1];
    assign sdi_lvl = sync_lvl[2];

    // Delay the synchronised serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
        end else begin
            sck_d <= sck_lvl;
        end
    end

    assign sck_rise = sck_lvl & ~sck_d;
    assign sck_fall = ~sck_lvl & sck_d;

    seq_conv_timer #(.SLOW_CYCLES(SLOW_CYCLES), .FAST_CYCLES(FAST_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_CONV),
        .fast_i (rate_fast_q),
        .done_o (tmr_done)
    );

    assign load_res   = (state_q == ST_CONV) && tmr_done;
    assign start_xfer = (state_q == ST_WAIT) && !cs_lvl;
    assign shift_bit  = (state_q == ST_XFER) && !cs_lvl && sck_fall;

    seq_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_res),
        .data_i  (sample_i),
        .start_i (start_xfer),
        .shift_i (shift_bit),
        .msb_o   (sdo_o),
        .done_o  (xfer_done)
    );

    // Phase sequencing and capture of configuration bits during transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_CONV;
            rate_fast_q <= 1'b0;
            sleep_q     <= 1'b0;
            rise_cnt_q  <= '0;
        end else begin
            case (state_q)
                ST_CONV: begin
                    if (tmr_done) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!cs_lvl) begin
                        state_q    <= ST_XFER;
                        rise_cnt_q <= '0;
                    end
                end
                ST_XFER: begin
                    if (cs_lvl) begin
                        state_q <= ST_CONV;
                    end else begin
                        if (sck_rise) begin
                            if (rise_cnt_q == RC_W'(0)) begin
                                rate_fast_q <= sdi_lvl;
                            end else if (rise_cnt_q == RC_W'(1)) begin
                                sleep_q <= sdi_lvl;
                            end
                            if (rise_cnt_q != RC_W'(CFG_BITS)) begin
                                rise_cnt_q <= rise_cnt_q + 1'b1;
                            end
                        end
                        if (xfer_done) state_q <= ST_CONV;
                    end
                end
                default: state_q <= ST_CONV;
            endcase
        end
    end

    assign sdo_oe_o     = ~cs_lvl;
    assign adc_pwr_en_o = (state_q == ST_CONV);
    assign ref_pwr_en_o = ~((state_q == ST_WAIT) && sleep_q);
endmodule

// File: rtl/seq_checks.sv
// Property checker for conv_spi_seq, attached with bind below.
// Assumes: reset is held low from time zero for at least three clocks.
module seq_checks
    import conv_spi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_i,
    input logic       sdo_o,
    input logic       sdo_oe_o,
    input logic       adc_pwr_en_o,
    input logic       ref_pwr_en_o,
    input seq_state_t state,
    input logic       tmr_done,
    input logic       cs_lvl
);
    p_conv_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_CONV && state != ST_CONV) |-> $past(tmr_done));

    p_conv_to_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_CONV && state != ST_CONV) |-> state == ST_WAIT);

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state) == ST_WAIT) |-> $stable(sdo_o));

    p_wait_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WAIT && state != ST_WAIT) |-> (state == ST_XFER && !$past(cs_lvl)));

    p_adc_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_pwr_en_o) |-> $past(state) == ST_XFER);

    p_ref_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state) == ST_WAIT) |-> $stable(ref_pwr_en_o));

    p_ref_on_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_pwr_en_o |-> ref_pwr_en_o);

    p_oe_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o == !$past(cs_n_i, 2));
endmodule

bind conv_spi_seq seq_checks u_seq_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n_i),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o),
    .adc_pwr_en_o (adc_pwr_en_o),
    .ref_pwr_en_o (ref_pwr_en_o),
    .state        (state_q),
    .tmr_done     (tmr_done),
    .cs_lvl       (cs_lvl)
);

// File: tb/conv_spi_seq_test.sv
`timescale 1ns/1ps
// Bench for conv_spi_seq: a behavioural model compared on every clock, plus directed checks.
module conv_spi_seq_test;
    localparam int SLOWC = 120;
    localparam int FASTC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sample = 16'hA5C3;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe, adc_en, ref_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference model
    int          m_st = 0;      // 0 converting, 1 waiting, 2 transferring
    int          m_cnt = 0;
    logic [15:0] m_res = 16'h0;
    int          m_nf = 0;
    int          m_nr = 0;
    bit          m_rate = 0;
    bit          m_sleep = 0;
    logic [3:0]  cs_h = 4'hF;
    logic [3:0]  sck_h = 4'h0;
    logic [3:0]  sdi_h = 4'h0;
    bit          model_live = 0;

    int run_len = 0;
    int lens[$];

    conv_spi_seq #(.DATA_W(16), .SLOW_CYCLES(SLOWC), .FAST_CYCLES(FASTC)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (sample),
        .cs_n_i       (cs_n),
        .sck_i        (sck),
        .sdi_i        (sdi),
        .sdo_o        (sdo),
        .sdo_oe_o     (sdo_oe),
        .adc_pwr_en_o (adc_en),
        .ref_pwr_en_o (ref_en)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model advances on each rising clock with the input values seen there.
    always @(posedge clk) begin
        cs_h  = {cs_h[2:0], cs_n};
        sck_h = {sck_h[2:0], sck};
        sdi_h = {sdi_h[2:0], sdi};
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_res = 16'h0; m_nf = 0; m_nr = 0;
            m_rate = 0; m_sleep = 0;
            cs_h = 4'hF; sck_h = 4'h0; sdi_h = 4'h0;
            model_live = 1;
        end else begin
            case (m_st)
                0: begin
                    if (m_cnt == (m_rate ? FASTC : SLOWC) - 1) begin
                        m_res = sample; m_st = 1; m_cnt = 0;
                    end else begin
                        m_cnt++;
                    end
                end
                1: if (!cs_h[2]) begin m_st = 2; m_nf = 0; m_nr = 0; end
                default: begin
                    if (cs_h[2]) begin
                        m_st = 0;
                    end else begin
                        if (sck_h[2] && !sck_h[3]) begin
                            if (m_nr == 0) m_rate = sdi_h[2];
                            else if (m_nr == 1) m_sleep = sdi_h[2];
                            if (m_nr < 2) m_nr++;
                        end
                        if (!sck_h[2] && sck_h[3]) begin
                            m_res = {m_res[14:0], 1'b0};
                            m_nf++;
                            if (m_nf == 16) m_st = 0;
                        end
                    end
                end
            endcase
        end
    end

    // Every-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_live && rst_n && !finished) begin
            chk("R6 adc_pwr_en vs model", adc_en, m_st == 0);
            chk("R7 ref_pwr_en vs model", ref_en, !(m_st == 1 && m_sleep));
            chk("R8 sdo_oe vs model", sdo_oe, !cs_h[1]);
            chk("R8 sdo vs model", sdo, m_res[15]);
        end
    end

    // Record the length of every converter-enable pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_en) run_len++;
            else if (run_len > 0) begin lens.push_back(run_len); run_len = 0; end
        end
    end

    task automatic wait_conv_end();
        for (int i = 0; i < 5000 && adc_en; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_len(input string tag, input int exp);
        if (lens.size() == 0) chk({tag, " no conversion recorded"}, 0, exp);
        else chk(tag, lens.pop_front(), exp);
    endtask

    // Run a transfer of nbits serial clocks; nbits below 16 ends in an abort.
    task automatic xfer(input bit rate, input bit slp, input bit rest,
                        input int nbits, output logic [15:0] got);
        got = 16'h0;
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i == 0) ? rate : (i == 1) ? slp : rest;
            repeat (2) @(negedge clk);
            got[15-i] = sdo;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
            if (i == 15) begin
                repeat (2) @(negedge clk);
                chk("R9 no restart before third edge", adc_en, 0);
                @(negedge clk);
                chk("R9 restart on third edge after 16th fall", adc_en, 1);
            end else begin
                repeat (4) @(negedge clk);
            end
        end
        if (nbits < 16) begin
            cs_n = 1'b1;
            repeat (2) @(negedge clk);
            chk("R10 no restart before third edge", adc_en, 0);
            @(negedge clk);
            chk("R10 abort restarts conversion", adc_en, 1);
        end else begin
            repeat (3) @(negedge clk);
            cs_n = 1'b1;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [15:0] got;
        repeat (5) @(negedge clk);
        chk("R1 reset adc_pwr_en", adc_en, 1);
        chk("R1 reset ref_pwr_en", ref_en, 1);
        chk("R1 reset sdo_oe", sdo_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 converting after reset", adc_en, 1);

        // first conversion (slow) then hold in wait with a changing sample
        wait_conv_end();
        void'(lens.pop_front());
        sample = 16'h0F0F;
        repeat (30) @(negedge clk);
        chk("R5 stays waiting while cs high", adc_en, 0);
        chk("R7 nap keeps reference on", ref_en, 1);
        chk("R8 output disabled while cs high", sdo_oe, 0);

        xfer(1'b1, 1'b0, 1'b0, 16, got);
        chk("R4 held word ignores sample change", got, 16'hA5C3);
        wait_conv_end();
        check_len("R11 fast rate conversion length R2", FASTC);

        sample = 16'h8001;
        xfer(1'b0, 1'b1, 1'b0, 16, got);
        chk("R4 second result", got, 16'h0F0F);
        repeat (10) @(negedge clk);
        cs_n = 1'b0;
        repeat (12) @(negedge clk);
        cs_n = 1'b1;
        wait_conv_end();
        check_len("R3 cs activity does not shorten slow conversion R2", SLOWC);
        repeat (5) @(negedge clk);
        chk("R7 sleep turns reference off", ref_en, 0);
        chk("R6 converter off in wait", adc_en, 0);

        sample = 16'h7FFE;
        xfer(1'b1, 1'b0, 1'b0, 5, got);
        chk("R10 bits before abort", got[15:11], 5'b10000);
        wait_conv_end();
        check_len("R10 config from aborted transfer gives fast length", FASTC);
        repeat (5) @(negedge clk);
        chk("R7 nap restored after aborted transfer", ref_en, 1);

        xfer(1'b0, 1'b0, 1'b1, 16, got);
        chk("R11 later serial bits ignored, result", got, 16'h7FFE);
        wait_conv_end();
        check_len("R11 later serial bits do not change rate", SLOWC);
        repeat (5) @(negedge clk);
        chk("R11 later serial bits do not select sleep", ref_en, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog R9 run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule